// File: doc/BRIEF.md
# Compound Adder with Shared Prefix Carry Network

This block adds two unsigned operands and returns the plain sum and the sum plus one in the same combinational pass. It serves the rounding stage of a floating-point adder: both candidate mantissa results exist before the rounding decision is known, so no incrementer sits after that decision. A select input then picks one of the two for a third output.

Every bit position gets a two-bit carry status: kill (neither operand bit set), propagate (exactly one set) or generate (both set). A parallel prefix network combines these statuses with an associative operator. When the upper status is propagate, the operator passes the lower status through. Otherwise it keeps the upper status. One prefix network serves both sums. For the plain sum, a carry enters bit i+1 when the prefix status at bit i is generate. For the incremented sum, the extra +1 acts as a generate placed below bit 0. This turns every prefix that is not kill into a carry. The network arrangement is a parameter: a Kogge-Stone network for minimum depth, or a Brent-Kung network for fewer operator cells.

Top module: `cpa_compound_adder`

## Requirements
- R1: `sum_plain` equals opnd_a + opnd_b as a WIDTH+1-bit unsigned value, with the carry-out in the top bit; carry statuses are encoded kill=2'b00, propagate=2'b01, generate=2'b10, and 2'b11 never appears.
- R2: `sum_plus1` equals opnd_a + opnd_b + 1 as a WIDTH+1-bit unsigned value, and is always exactly one above `sum_plain`.
- R3: `sum_sel` equals `sum_plus1` while round_up is 1 and `sum_plain` while round_up is 0.
- R4: round_up has no effect on `sum_plain` or `sum_plus1`.
- R5: PREFIX_ARCH=0 (Kogge-Stone) and PREFIX_ARCH=1 (Brent-Kung) give identical outputs for identical inputs.
- R6: With both operands all ones, `sum_plain` is 2^(WIDTH+1)-2 and `sum_plus1` is 2^(WIDTH+1)-1.
- R7: With both operands zero, `sum_plain` is 0 and `sum_plus1` is 1.
- R8: The prefix status at bit 0 equals the status of bit 0. With opnd_a=4'b0100 and opnd_b=4'b1110 (upper bits zero), `sum_plain` is 18 and `sum_plus1` is 19.
- R9: Every carry of the plain sum is also a carry of the incremented sum, and bit 0 of `sum_plus1` is the complement of bit 0 of `sum_plain`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First unsigned operand |
| opnd_b | input | WIDTH | Second unsigned operand |
| round_up | input | 1 | Selects the incremented sum on sum_sel when high |
| sum_plain | output | WIDTH+1 | opnd_a + opnd_b including carry-out |
| sum_plus1 | output | WIDTH+1 | opnd_a + opnd_b + 1 including carry-out |
| sum_sel | output | WIDTH+1 | Sum chosen by round_up |

## Verification
A wrong status code or a wrong prefix combination at any level corrupts the carry into some bit. The damage shows at once, as a wrong sum for the operand patterns whose carry chain runs through that cell. Each result is compared to integer arithmetic within the same cycle its inputs are applied. The 6-bit instances are driven through every operand pair, so every prefix cell and every carry chain length is exercised. The 32-bit instances get random operands and the all-ones chain that runs through the full width. A fault that touches only the incremented path breaks the fixed gap of one between the two sums on the next input change.

// File: rtl/cpa_pkg.sv
package cpa_pkg;

    typedef logic [1:0] cstat_t;

    localparam cstat_t ST_KILL = 2'b00;
    localparam cstat_t ST_PROP = 2'b01;
    localparam cstat_t ST_GEN  = 2'b10;

    localparam int ARCH_KOGGE_STONE = 0;
    localparam int ARCH_BRENT_KUNG  = 1;

    // Combine an upper span status with the status of the span just below it.
    function automatic cstat_t cstat_join(cstat_t upper, cstat_t lower);
        cstat_t res;
        if (upper == ST_PROP) begin
            res = lower;
        end else begin
            res = upper;
        end
        return res;
    endfunction

endpackage

// File: rtl/cpa_status_gen.sv
module cpa_status_gen
    import cpa_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]      opnd_a,
    input  logic [WIDTH-1:0]      opnd_b,
    output logic [WIDTH-1:0][1:0] stat_d
);

    // Generate flag in the upper bit, propagate flag in the lower bit.
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        always_comb begin
            stat_d[gi] = {opnd_a[gi] & opnd_b[gi], opnd_a[gi] ^ opnd_b[gi]};
        end
    end

endmodule

// File: rtl/cpa_prefix_net.sv
module cpa_prefix_net
    import cpa_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int ARCH  = ARCH_KOGGE_STONE
) (
    input  logic [WIDTH-1:0][1:0] stat_d,
    output logic [WIDTH-1:0][1:0] pfx_d
);

    localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 1;

    if (ARCH == ARCH_KOGGE_STONE) begin : g_ks
        // Each level doubles the span of every position; descending order
        // keeps the lower operand at its previous-level value.
        always_comb begin
            logic [WIDTH-1:0][1:0] work_d;
            work_d = stat_d;
            for (int lv = 0; lv < LEVELS; lv++) begin
                for (int i = WIDTH - 1; i >= 0; i--) begin
                    if (i >= (1 << lv)) begin
                        work_d[i] = cstat_join(work_d[i],
                                               work_d[(i >= (1 << lv)) ? i - (1 << lv) : 0]);
                    end
                end
            end
            pfx_d = work_d;
        end
    end else begin : g_bk
        // Up-sweep builds power-of-two spans, down-sweep fills the gaps.
        always_comb begin
            logic [WIDTH-1:0][1:0] work_d;
            work_d = stat_d;
            for (int lv = 0; lv < LEVELS; lv++) begin
                for (int i = 0; i < WIDTH; i++) begin
                    if ((i % (2 << lv)) == ((2 << lv) - 1)) begin
                        work_d[i] = cstat_join(work_d[i],
                                               work_d[(i >= (1 << lv)) ? i - (1 << lv) : 0]);
                    end
                end
            end
            for (int lv = LEVELS - 2; lv >= 0; lv--) begin
                for (int i = 0; i < WIDTH; i++) begin
                    if ((i >= (3 << lv) - 1) && (((i - ((3 << lv) - 1)) % (2 << lv)) == 0)) begin
                        work_d[i] = cstat_join(work_d[i],
                                               work_d[(i >= (1 << lv)) ? i - (1 << lv) : 0]);
                    end
                end
            end
            pfx_d = work_d;
        end
    end

    // Guards on the network output against the raw statuses.
    always_comb begin
        if (!$isunknown(stat_d)) begin
            assert_pfx_base_R8: assert (pfx_d[0] == stat_d[0])
                else $error("prefix at bit 0 differs from its own status");
            for (int i = 0; i < WIDTH; i++) begin
                assert_pfx_code_R1: assert (pfx_d[i] != 2'b11)
                    else $error("illegal prefix status code at bit %0d", i);
            end
        end
    end

endmodule

// File: rtl/cpa_sum_form.sv
module cpa_sum_form
    import cpa_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]      opnd_a,
    input  logic [WIDTH-1:0]      opnd_b,
    input  logic [WIDTH-1:0][1:0] pfx_d,
    output logic [WIDTH:0]        sum_plain,
    output logic [WIDTH:0]        sum_plus1
);

    logic [WIDTH:0] cy_plain_d;
    logic [WIDTH:0] cy_plus1_d;

    always_comb begin
        cy_plain_d[0] = 1'b0;
        cy_plus1_d[0] = 1'b1;
        for (int i = 0; i < WIDTH; i++) begin
            cy_plain_d[i+1] = (pfx_d[i] == ST_GEN);
            cy_plus1_d[i+1] = (pfx_d[i] != ST_KILL);
        end
    end

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            sum_plain[i] = opnd_a[i] ^ opnd_b[i] ^ cy_plain_d[i];
            sum_plus1[i] = opnd_a[i] ^ opnd_b[i] ^ cy_plus1_d[i];
        end
        sum_plain[WIDTH] = cy_plain_d[WIDTH];
        sum_plus1[WIDTH] = cy_plus1_d[WIDTH];
    end

    always_comb begin
        if (!$isunknown({opnd_a, opnd_b, pfx_d})) begin
            assert_carry_cover_R9: assert ((cy_plain_d & ~cy_plus1_d) == '0)
                else $error("plain carry without incremented carry");
            assert_lsb_flip_R9: assert (sum_plus1[0] != sum_plain[0])
                else $error("low bits of the two sums agree");
        end
    end

endmodule

// File: rtl/cpa_compound_adder.sv
module cpa_compound_adder
    import cpa_pkg::*;
#(
    parameter int WIDTH       = 32,
    parameter int PREFIX_ARCH = ARCH_KOGGE_STONE
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             round_up,
    output logic [WIDTH:0]   sum_plain,
    output logic [WIDTH:0]   sum_plus1,
    output logic [WIDTH:0]   sum_sel
);

    localparam logic [WIDTH:0] ONE = {{WIDTH{1'b0}}, 1'b1};

    logic [WIDTH-1:0][1:0] stat_d;
    logic [WIDTH-1:0][1:0] pfx_d;

    cpa_status_gen #(.WIDTH(WIDTH)) u_status (
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .stat_d (stat_d)
    );

    cpa_prefix_net #(.WIDTH(WIDTH), .ARCH(PREFIX_ARCH)) u_prefix (
        .stat_d (stat_d),
        .pfx_d  (pfx_d)
    );

    cpa_sum_form #(.WIDTH(WIDTH)) u_sum (
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .pfx_d     (pfx_d),
        .sum_plain (sum_plain),
        .sum_plus1 (sum_plus1)
    );

    always_comb begin
        sum_sel = round_up ? sum_plus1 : sum_plain;
    end

    always_comb begin
        if (!$isunknown({opnd_a, opnd_b})) begin
            assert_plus_one_gap_R2: assert (sum_plus1 == sum_plain + ONE)
                else $error("incremented sum is not one above plain sum");
        end
    end

endmodule

// File: tb/cpa_compound_adder_tb.sv
module cpa_compound_adder_tb;

    localparam int WB = 32;
    localparam int WS = 6;
    localparam longint BIG_ONES = (longint'(1) << (WB + 1));
    localparam longint SML_ONES = (longint'(1) << (WS + 1));

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n;
    logic          live;
    logic [WB-1:0] a_b, b_b;
    logic          ru_b;
    logic [WS-1:0] a_s, b_s;
    logic          ru_s;

    logic [WB:0] ks_sum, ks_inc, ks_sel, bk_sum, bk_inc, bk_sel;
    logic [WS:0] sk_sum, sk_inc, sk_sel, sb_sum, sb_inc, sb_sel;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    cpa_compound_adder #(.WIDTH(WB), .PREFIX_ARCH(0)) u_dut (
        .opnd_a(a_b), .opnd_b(b_b), .round_up(ru_b),
        .sum_plain(ks_sum), .sum_plus1(ks_inc), .sum_sel(ks_sel));

    cpa_compound_adder #(.WIDTH(WB), .PREFIX_ARCH(1)) u_dut_bk (
        .opnd_a(a_b), .opnd_b(b_b), .round_up(ru_b),
        .sum_plain(bk_sum), .sum_plus1(bk_inc), .sum_sel(bk_sel));

    cpa_compound_adder #(.WIDTH(WS), .PREFIX_ARCH(0)) u_small_ks (
        .opnd_a(a_s), .opnd_b(b_s), .round_up(ru_s),
        .sum_plain(sk_sum), .sum_plus1(sk_inc), .sum_sel(sk_sel));

    cpa_compound_adder #(.WIDTH(WS), .PREFIX_ARCH(1)) u_small_bk (
        .opnd_a(a_s), .opnd_b(b_s), .round_up(ru_s),
        .sum_plain(sb_sum), .sum_plus1(sb_inc), .sum_sel(sb_sel));

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference, compared on every falling edge.
    always @(negedge clk) begin
        if (live && rst_n && !done) begin
            longint rb, rs;
            rb = longint'(a_b) + longint'(b_b);
            rs = longint'(a_s) + longint'(b_s);
            chk("R1 plain sum wide KS", longint'(ks_sum), rb);
            chk("R2 plus-one sum wide KS", longint'(ks_inc), rb + 1);
            chk("R3 selected sum wide KS", longint'(ks_sel), ru_b ? rb + 1 : rb);
            chk("R5 wide BK plain", longint'(bk_sum), rb);
            chk("R5 wide BK plus-one", longint'(bk_inc), rb + 1);
            chk("R5 wide BK selected", longint'(bk_sel), ru_b ? rb + 1 : rb);
            chk("R1 plain sum small KS", longint'(sk_sum), rs);
            chk("R2 plus-one sum small KS", longint'(sk_inc), rs + 1);
            chk("R3 selected sum small KS", longint'(sk_sel), ru_s ? rs + 1 : rs);
            chk("R5 small BK plain", longint'(sb_sum), rs);
            chk("R5 small BK plus-one", longint'(sb_inc), rs + 1);
            chk("R5 small BK selected", longint'(sb_sel), ru_s ? rs + 1 : rs);
            if (ru_b) begin
                chk("R4 plain sum with round_up high", longint'(ks_sum), rb);
                chk("R4 plus-one sum with round_up high", longint'(bk_inc), rb + 1);
            end
        end
    end

    task automatic drive(input logic [WB-1:0] ab, input logic [WB-1:0] bb, input logic rub,
                         input logic [WS-1:0] as, input logic [WS-1:0] bs, input logic rus);
        @(posedge clk);
        a_b  = ab;
        b_b  = bb;
        ru_b = rub;
        a_s  = as;
        b_s  = bs;
        ru_s = rus;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        rst_n = 1'b0;
        live  = 1'b0;
        a_b = '0; b_b = '0; ru_b = 1'b0;
        a_s = '0; b_s = '0; ru_s = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        live  = 1'b1;

        // R7: zero operands straight after reset.
        @(negedge clk);
        chk("R7 zero operands plain", longint'(ks_sum), 0);
        chk("R7 zero operands plus-one", longint'(ks_inc), 1);
        chk("R7 zero operands small BK plus-one", longint'(sb_inc), 1);

        // R6: all-ones operands, longest carry chain.
        drive('1, '1, 1'b0, '1, '1, 1'b1);
        @(negedge clk);
        chk("R6 all ones wide plain", longint'(ks_sum), BIG_ONES - 2);
        chk("R6 all ones wide plus-one", longint'(bk_inc), BIG_ONES - 1);
        chk("R6 all ones small plain", longint'(sb_sum), SML_ONES - 2);
        chk("R6 all ones small selected", longint'(sk_sel), SML_ONES - 1);

        // R8: worked example 0100 + 1110.
        drive(32'd4, 32'd14, 1'b1, 6'd4, 6'd14, 1'b0);
        @(negedge clk);
        chk("R8 example small plain", longint'(sk_sum), 18);
        chk("R8 example small plus-one", longint'(sb_inc), 19);
        chk("R8 example wide selected", longint'(ks_sel), 19);

        // R4: same operands, round_up toggled; both sums hold.
        drive(32'hDEAD_BEEF, 32'h1234_5678, 1'b0, 6'd33, 6'd30, 1'b0);
        @(negedge clk);
        chk("R4 plain before toggle", longint'(ks_sum), 64'h0_F0E2_1567);
        drive(32'hDEAD_BEEF, 32'h1234_5678, 1'b1, 6'd33, 6'd30, 1'b1);
        @(negedge clk);
        chk("R4 plain after toggle", longint'(ks_sum), 64'h0_F0E2_1567);
        chk("R4 small plus-one after toggle", longint'(sk_inc), 64);

        // R9: low bits of the two sums always differ (sampled via ports).
        @(negedge clk);
        chk("R9 low bit complement", longint'(ks_sum[0] ^ ks_inc[0]), 1);

        // Exhaustive small operands, random wide operands.
        for (int ia = 0; ia < (1 << WS); ia++) begin
            for (int ib = 0; ib < (1 << WS); ib++) begin
                logic [WB-1:0] ra, rbv;
                ra  = $urandom;
                rbv = $urandom;
                if ((ib % 16) == 3) ra = '1;
                if ((ib % 16) == 7) rbv = '1;
                if ((ib % 32) == 11) rbv = ~ra;
                drive(ra, rbv, 1'($urandom), 6'(ia), 6'(ib), 1'((ia ^ ib) & 1));
            end
        end
        @(negedge clk);
        chk("R9 low bit complement at end", longint'(sb_sum[0] ^ sb_inc[0]), 1);
        @(posedge clk);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

endmodule